// File: doc/BRIEF.md
# Decimal Carry-Save to BCD Converter

This block finishes a decimal multiplication. A decimal product that is held in carry-save form has two parts. The first is a vector of decimal digits, each 0 to 9. The second is a vector of single carry bits, one bit for each digit position, where each bit weighs one unit of its own position. The block adds the two parts and returns a plain BCD number of the same width. The default width is 32 digits, which is the full product of two 16-digit operands. The result is never rounded or cut short.

Each digit slice works out its raw sum. It marks the slice as *propagate* when the sum is exactly nine and as *generate* when the sum is exactly ten. It also works out two candidate digits in advance: one for an incoming carry of zero and one for an incoming carry of one. A parallel-prefix network (Kogge-Stone form) finds every digit carry at the same time from these marks. Each slice then selects the candidate that matches its own carry.

A second mode turns the unit into a general BCD adder. A front compression step folds two BCD vectors into the same digit-plus-bit form, and the same converter then finishes the sum. The result is captured in one output register that has an active-low asynchronous reset.

Top module: `dcs_to_bcd`

## Requirements
- R1: With `add_mode`=0, `sum_dig` = (A + D) mod 10^NDIG. Digit i of A sits in bits [4i+3:4i] of `a_dig`, and bit i of `d_bit` adds 10^i.
- R2: A digit slice whose digit-plus-bit sum is ten outputs 0 for that position and passes a carry of one into the next position.
- R3: Nothing carries into digit 0. Output digit 0 is always (a0 + d0) mod 10.
- R4: The carry into every digit equals the carry a digit-by-digit ripple would give. A single generate at digit 0 travels through a run of nines up to the top digit.
- R5: With `add_mode`=1, `sum_dig` = (A + B) mod 10^NDIG, where digit i of B sits in bits [4i+3:4i] of `b_dig`. `d_bit` has no effect on the result.
- R6: With `add_mode`=0, `b_dig` has no effect on the result.
- R7: Every output digit is a valid BCD code, 0 to 9.
- R8: A carry out of the most significant digit is dropped. All nines plus one gives zero in both modes.
- R9: The result is registered. It appears on `sum_dig` after the first rising clock edge that follows the input change, and it holds its old value until that edge.
- R10: While `rst_n` is low, `sum_dig` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| add_mode | input | 1 | 0: digit-plus-bit conversion; 1: two-operand BCD add |
| a_dig | input | NDIG*4 (128) | Digit vector A, BCD, digit 0 in the low nibble |
| b_dig | input | NDIG*4 (128) | Second BCD operand, used only when `add_mode`=1 |
| d_bit | input | NDIG (32) | Carry bits, one per digit, used only when `add_mode`=0 |
| sum_dig | output | NDIG*4 (128) | Registered BCD result |

## Verification
Every result is due one rising edge after its inputs settle, because a single register sits between the inputs and `sum_dig`. The bench drives new operands on the falling edge. It checks the matching result on the next falling edge, so exactly one capturing edge lies between stimulus and sample. For the latency requirement, the bench also samples one time unit after a change, before that edge, and expects the previous result. A 3-digit instance is swept exhaustively in conversion mode and on a strided grid in add mode. A default 32-digit instance covers random operands and long carry chains.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int DIG_W = 4;

    typedef logic [DIG_W-1:0] bcd_digit_t;

    // reduce a value in 0..19 to a single decimal digit
    function automatic bcd_digit_t mod10(input logic [4:0] v);
        logic [4:0] r;
        r = (v >= 5'd10) ? (v - 5'd10) : v;
        return r[DIG_W-1:0];
    endfunction

endpackage

// File: rtl/dcs_compress.sv
// Folds two BCD vectors into digit-plus-bit form for the adder mode.
module dcs_compress #(
    parameter int NDIG = 32
) (
    input  logic [NDIG*dcs_pkg::DIG_W-1:0] x_dig,
    input  logic [NDIG*dcs_pkg::DIG_W-1:0] y_dig,
    output logic [NDIG*dcs_pkg::DIG_W-1:0] w_dig,
    output logic [NDIG-1:0]                e_bit
);
    localparam int DW = dcs_pkg::DIG_W;

    always_comb begin
        logic [4:0] t;
        logic       k;
        k = 1'b0;
        for (int i = 0; i < NDIG; i++) begin
            t = {1'b0, x_dig[DW*i +: DW]} + {1'b0, y_dig[DW*i +: DW]};
            e_bit[i] = k;
            w_dig[DW*i +: DW] = dcs_pkg::mod10(t);
            k = (t >= 5'd10);
        end
    end

    // compressed digits must stay decimal so the converter sees legal input
    always_comb begin
        for (int i = 0; i < NDIG; i++) begin
            assert_compress_digit_R5: assert (w_dig[DW*i +: DW] <= 4'd9 ||
                                              x_dig[DW*i +: DW] > 4'd9 ||
                                              y_dig[DW*i +: DW] > 4'd9);
        end
    end

endmodule

// File: rtl/dcs_digit.sv
// One digit slice: propagate/generate flags and both candidate digits.
module dcs_digit (
    input  dcs_pkg::bcd_digit_t a,
    input  logic                d,
    output logic                p,
    output logic                g,
    output dcs_pkg::bcd_digit_t s0,
    output dcs_pkg::bcd_digit_t s1
);
    logic [4:0] raw;
    logic [4:0] raw_inc;

    always_comb begin
        raw     = {1'b0, a} + {4'b0000, d};
        raw_inc = raw + 5'd1;
        p       = (raw == 5'd9);
        g       = (raw == 5'd10);
        s0      = dcs_pkg::mod10(raw);
        s1      = dcs_pkg::mod10(raw_inc);
    end

endmodule

// File: rtl/dcs_prefix.sv
// Kogge-Stone carry network over per-digit (g,p); carry into digit 0 is zero.
module dcs_prefix #(
    parameter int NDIG = 32
) (
    input  logic [NDIG-1:0] g_in,
    input  logic [NDIG-1:0] p_in,
    output logic [NDIG-1:0] carry
);
    localparam int LV = (NDIG > 1) ? $clog2(NDIG) : 1;

    always_comb begin
        logic [NDIG-1:0] gv, pv, gn, pn;
        gv = g_in;
        pv = p_in;
        for (int l = 0; l < LV; l++) begin
            gn = gv;
            pn = pv;
            for (int i = 0; i < NDIG; i++) begin
                if (i >= (1 << l)) begin
                    gn[i] = gv[i] | (pv[i] & gv[i - (1 << l)]);
                    pn[i] = pv[i] & pv[i - (1 << l)];
                end
            end
            gv = gn;
            pv = pn;
        end
        carry[0] = 1'b0;
        for (int i = 1; i < NDIG; i++) begin
            carry[i] = gv[i-1];
        end
    end

    // independent digit-serial ripple as a cross-check of the tree
    always_comb begin
        logic c;
        c = 1'b0;
        for (int i = 0; i < NDIG; i++) begin
            assert_prefix_matches_ripple_R4: assert (carry[i] == c);
            c = g_in[i] | (p_in[i] & c);
        end
    end

endmodule

// File: rtl/dcs_to_bcd.sv
module dcs_to_bcd #(
    parameter int NDIG = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 add_mode,
    input  logic [NDIG*4-1:0]    a_dig,
    input  logic [NDIG*4-1:0]    b_dig,
    input  logic [NDIG-1:0]      d_bit,
    output logic [NDIG*4-1:0]    sum_dig
);
    localparam int DW = dcs_pkg::DIG_W;
    localparam int VW = NDIG * DW;

    logic [VW-1:0]   w_dig;
    logic [NDIG-1:0] e_bit;
    logic [VW-1:0]   op_dig;
    logic [NDIG-1:0] op_bit;
    logic [NDIG-1:0] prop;
    logic [NDIG-1:0] gen;
    logic [VW-1:0]   cand0;
    logic [VW-1:0]   cand1;
    logic [NDIG-1:0] carry;
    logic [VW-1:0]   sel_dig;
    logic            past_ok;

    dcs_compress #(.NDIG(NDIG)) u_cmp (
        .x_dig (a_dig),
        .y_dig (b_dig),
        .w_dig (w_dig),
        .e_bit (e_bit)
    );

    always_comb begin
        op_dig = add_mode ? w_dig : a_dig;
        op_bit = add_mode ? e_bit : d_bit;
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_slice
        dcs_digit u_dig (
            .a  (op_dig[DW*i +: DW]),
            .d  (op_bit[i]),
            .p  (prop[i]),
            .g  (gen[i]),
            .s0 (cand0[DW*i +: DW]),
            .s1 (cand1[DW*i +: DW])
        );
    end

    dcs_prefix #(.NDIG(NDIG)) u_pfx (
        .g_in  (gen),
        .p_in  (prop),
        .carry (carry)
    );

    always_comb begin
        for (int i = 0; i < NDIG; i++) begin
            sel_dig[DW*i +: DW] = carry[i] ? cand1[DW*i +: DW] : cand0[DW*i +: DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_dig <= '0;
            past_ok <= 1'b0;
        end else begin
            sum_dig <= sel_dig;
            past_ok <= 1'b1;
        end
    end

    // digit 0 never receives a carry
    assert_lsd_no_carry_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(add_mode)) |->
        sum_dig[DW-1:0] == dcs_pkg::mod10({1'b0, $past(a_dig[DW-1:0])} + {4'b0000, $past(d_bit[0])}));

    for (genvar i = 0; i < NDIG; i++) begin : g_chk
        assert_digit_bcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !$past(add_mode) && $past(a_dig[DW*i +: DW]) <= 4'd9) |->
            sum_dig[DW*i +: DW] <= 4'd9);
    end

endmodule

// File: tb/dcs_to_bcd_tb.sv
module dcs_to_bcd_tb;

    localparam int CLK_P = 10;
    localparam int SN    = 3;
    localparam int WN    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic            s_m = 1'b0;
    logic [SN*4-1:0] s_a = '0, s_b = '0, s_sum;
    logic [SN-1:0]   s_d = '0;
    logic            w_m = 1'b0;
    logic [WN*4-1:0] w_a = '0, w_b = '0, w_sum;
    logic [WN-1:0]   w_d = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    dcs_to_bcd #(.NDIG(SN)) u_dut (
        .clk(clk), .rst_n(rst_n), .add_mode(s_m),
        .a_dig(s_a), .b_dig(s_b), .d_bit(s_d), .sum_dig(s_sum)
    );

    dcs_to_bcd #(.NDIG(WN)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .add_mode(w_m),
        .a_dig(w_a), .b_dig(w_b), .d_bit(w_d), .sum_dig(w_sum)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [SN*4-1:0] to_bcd3(input int v);
        logic [SN*4-1:0] r;
        int t;
        t = v;
        for (int i = 0; i < SN; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int dweight3(input int dv);
        return (dv & 1) + 10 * ((dv >> 1) & 1) + 100 * ((dv >> 2) & 1);
    endfunction

    function automatic logic [WN*4-1:0] dec_add(input logic [WN*4-1:0] x, input logic [WN*4-1:0] y);
        logic [WN*4-1:0] r;
        int c, t;
        c = 0;
        for (int i = 0; i < WN; i++) begin
            t = int'(x[4*i +: 4]) + int'(y[4*i +: 4]) + c;
            r[4*i +: 4] = 4'(t % 10);
            c = t / 10;
        end
        return r;
    endfunction

    function automatic logic [WN*4-1:0] bits_to_dig(input logic [WN-1:0] d);
        logic [WN*4-1:0] r;
        for (int i = 0; i < WN; i++) r[4*i +: 4] = {3'b000, d[i]};
        return r;
    endfunction

    function automatic logic [WN*4-1:0] rand_dig();
        logic [WN*4-1:0] r;
        for (int i = 0; i < WN; i++) r[4*i +: 4] = 4'($urandom % 10);
        return r;
    endfunction

    function automatic logic [WN*4-1:0] fill(input logic [3:0] v);
        logic [WN*4-1:0] r;
        for (int i = 0; i < WN; i++) r[4*i +: 4] = v;
        return r;
    endfunction

    function automatic bit all_bcd(input logic [WN*4-1:0] v);
        for (int i = 0; i < WN; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wide_step(input logic m, input logic [WN*4-1:0] a,
                             input logic [WN*4-1:0] b, input logic [WN-1:0] d);
        w_m = m; w_a = a; w_b = b; w_d = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        logic [WN*4-1:0] ra, rb, prev;
        logic [WN-1:0]   rd;

        // R10: reset holds outputs at zero
        s_a = to_bcd3(987); s_d = 3'b111;
        w_a = fill(4'd9);   w_d = '1;
        repeat (2) @(negedge clk);
        chk("R10 small reset", s_sum, '0);
        chk("R10 wide reset", w_sum, '0);
        rst_n = 1'b1;

        // R1/R6: exhaustive conversion sweep on the 3-digit instance, B random
        for (int av = 0; av < 1000; av++) begin
            for (int dv = 0; dv < 8; dv++) begin
                s_m = 1'b0;
                s_a = to_bcd3(av);
                s_d = 3'(dv);
                s_b = to_bcd3(int'($urandom % 1000));
                @(negedge clk);
                chk("R1/R6 conv sweep", s_sum, to_bcd3((av + dweight3(dv)) % 1000));
            end
        end

        // R5/R8: add-mode grid, D random and ignored, wrap above 999
        for (int av = 0; av < 1000; av++) begin
            for (int bv = 0; bv < 1000; bv += 13) begin
                s_m = 1'b1;
                s_a = to_bcd3(av);
                s_b = to_bcd3(bv);
                s_d = 3'($urandom % 8);
                @(negedge clk);
                chk("R5 add sweep", s_sum, to_bcd3((av + bv) % 1000));
            end
        end

        // R8: all nines plus one wraps to zero, both modes
        wide_step(1'b0, fill(4'd9), '0, 32'h1);
        chk("R8 conv wrap", w_sum, '0);
        wide_step(1'b1, fill(4'd9), {{(WN*4-4){1'b0}}, 4'd1}, '0);
        chk("R8 add wrap", w_sum, '0);

        // R4: generate at digit 0 rides a run of nines to the top digit
        ra = fill(4'd9); ra[WN*4-1 -: 4] = 4'd0;
        wide_step(1'b0, ra, '0, 32'h1);
        chk("R4 long chain", w_sum, {4'd1, {(WN*4-4){1'b0}}});

        // R2: digit sum of ten gives 0 here and bumps the next digit
        ra = '0; ra[3:0] = 4'd9; ra[7:4] = 4'd3;
        wide_step(1'b0, ra, '0, 32'h1);
        chk("R2 gen digit", w_sum, {{(WN*4-8){1'b0}}, 4'd4, 4'd0});

        // R3: digit 0 at nine with no bit stays nine
        ra = fill(4'd9); ra[3:0] = 4'd9;
        wide_step(1'b0, ra, '0, 32'hFFFF_FFFE);
        chk("R3 no carry-in", w_sum[3:0], 4'd9);

        // R6: B has no effect in conversion mode
        ra = rand_dig(); rd = $urandom;
        wide_step(1'b0, ra, fill(4'd9), rd);
        prev = w_sum;
        wide_step(1'b0, ra, '0, rd);
        chk("R6 b ignored", w_sum, prev);

        // R5: D has no effect in add mode
        ra = rand_dig(); rb = rand_dig();
        wide_step(1'b1, ra, rb, '1);
        prev = w_sum;
        wide_step(1'b1, ra, rb, '0);
        chk("R5 d ignored", w_sum, prev);

        // R9: output holds until the capturing edge
        prev = w_sum;
        w_m = 1'b0; w_a = fill(4'd1); w_b = '0; w_d = '0;
        #1;
        chk("R9 hold before edge", w_sum, prev);
        @(negedge clk);
        chk("R9 new after edge", w_sum, fill(4'd1));

        // R1/R5/R7: random wide operands
        for (int k = 0; k < 300; k++) begin
            ra = rand_dig(); rb = rand_dig(); rd = $urandom;
            wide_step(1'b0, ra, rb, rd);
            chk("R1 wide conv", w_sum, dec_add(ra, bits_to_dig(rd)));
            chk("R7 digits bcd", 128'(all_bcd(w_sum)), 128'(1));
            wide_step(1'b1, ra, rb, rd);
            chk("R5 wide add", w_sum, dec_add(ra, rb));
        end

        // R10: asynchronous reset clears a live result
        wide_step(1'b0, fill(4'd5), '0, '0);
        rst_n = 1'b0;
        #1;
        chk("R10 async clear", w_sum, '0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

endmodule